// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month with a century flag, and a two-digit year. A 15-bit prescaler (width set by a parameter) counts enable pulses from a 32.768 kHz clock-enable input. Each time it wraps, the seconds field advances one step, and carries ripple up through the minutes, hours and calendar fields. The hours byte works in one of two formats, chosen by its own bit 6: a 24-hour count, or a 12-hour count with a PM flag.

Any field can be loaded through a single-cycle write port. A write to the seconds field also restarts the sub-second prescaler, so the next increment falls one full second after the load. A halt input freezes the whole chain while it is held. Two outputs serve alarm logic further down the chip. The first is a one-cycle strobe on every seconds increment. The second is a 1 Hz phase signal that rises half a second into each second. Values loaded that are not legal BCD, or are out of range, give undefined results.

Top module: `bcd_rtc_counter`

## Requirements
- R1: Seconds (address 0) and minutes (address 1) count in BCD from 00 to 59. Moving from 59 to 00 carries into the next field, and a lower digit of 9 carries into the tens digit.
- R2: When hours (address 2) bit 6 is 0, the hours field holds a BCD value from 00 to 23. A roll from 23:59:59 to 00:00:00 advances the calendar by one day.
- R3: When hours bit 6 is 1, bits 4:0 hold a BCD value from 1 to 12 and bit 5 = 1 means PM. The order runs 11→12 with the PM flag flipped, then 12→1. The day advances only on the PM→AM flip, which is 11 PM → 12 AM.
- R4: Day of week (address 3) steps by one on each day advance and wraps from 7 to 1.
- R5: Day of month (address 4) wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the binary value of the year is divisible by 4, and 28 days otherwise. All other months have 31 days.
- R6: Month (address 5, BCD in bits 4:0) wraps from 12 to 01 and advances the year (address 6). A year roll from 99 to 00 inverts month bit 7, the century flag.
- R7: A write to seconds clears the prescaler. The next seconds step follows 2^PRESC_BITS enabled ticks later. The phase output is low in the first half of that second and goes high after 2^(PRESC_BITS-1) ticks.
- R8: While osc_halt is 1, the prescaler and every field hold their values.
- R9: sec_tick is high for exactly one cycle per seconds increment, during the cycle before the field changes.
- R10: A write through the port sets the addressed field on the next edge. It takes priority over a carry into that field in the same cycle.
- R11: Reset sets the time to 00:00:00 in 24-hour format, day of week to 1, the date to 01, the month to 01 with the century flag at 0, and the year to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| osc_halt | input | 1 | 1 stops the time base |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field select: 0 sec, 1 min, 2 hour, 3 weekday, 4 date, 5 month, 6 year |
| wr_data | input | 8 | BCD byte to load |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours with format and PM bits |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month, bit 7 century flag |
| year_o | output | 8 | Year |
| sec_tick | output | 1 | Seconds increment strobe |
| phase_1hz | output | 1 | 1 Hz phase output |

## Verification
Embedded assertions check on every cycle the local carry rules:
- seconds 59→00;
- 23→00 and 11 PM→12 AM on an hour carry;
- weekday 7→1 and the wrap from day 31;
- the century flip;
- write priority;
- the halt freeze;
- the phase reset after a seconds load;
- the one-cycle width of the strobe.

Only the bench scenarios can show month lengths, leap years, full carry chains through to the year, and the exact tick count between a seconds load and the next increment.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W = 8;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOW   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MONTH = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR  = 3'd6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // last legal day of month, BCD
  function automatic logic [7:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
    logic [6:0] yb;
    yb = bcd_to_bin(yr);
    case (mon)
      5'h02:                      return ((yb % 7'd4) == 7'd0) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic halt,
  input  logic restart,
  output logic sec_tick,
  output logic phase
);
  localparam logic [PRESC_BITS-1:0] CNT_MAX = '1;

  logic [PRESC_BITS-1:0] cnt_q, cnt_d;
  logic                  advance;

  assign advance  = tick_in && !halt;
  assign sec_tick = advance && (cnt_q == CNT_MAX) && !restart;
  assign phase    = cnt_q[PRESC_BITS-1];

  always_comb begin
    cnt_d = cnt_q;
    if (restart)      cnt_d = '0;
    else if (advance) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !phase);
  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_step,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] sec_q,
  output logic [FIELD_W-1:0] min_q,
  output logic [FIELD_W-1:0] hour_q,
  output logic               day_step
);
  logic [FIELD_W-1:0] sec_d, min_d, hour_d, hour_nx;
  logic [FIELD_W-1:0] sec_inc, min_inc, hr_inc;
  logic sec_wr, min_wr, hour_wr;
  logic min_step, hour_step, turnover;

  assign sec_wr  = wr_en && (wr_addr == A_SEC);
  assign min_wr  = wr_en && (wr_addr == A_MIN);
  assign hour_wr = wr_en && (wr_addr == A_HOUR);

  assign sec_inc   = bcd_inc(sec_q);
  assign min_inc   = bcd_inc(min_q);
  assign min_step  = sec_step && (sec_q == 8'h59);
  assign hour_step = min_step && (min_q == 8'h59);
  assign day_step  = hour_step && turnover;

  always_comb begin
    turnover = 1'b0;
    if (hour_q[6]) begin
      hr_inc = bcd_inc({3'b000, hour_q[4:0]});
      if (hour_q[4:0] == 5'h11) begin
        hour_nx  = {hour_q[7:6], ~hour_q[5], 5'h12};
        turnover = hour_q[5];
      end else if (hour_q[4:0] == 5'h12) begin
        hour_nx = {hour_q[7:5], 5'h01};
      end else begin
        hour_nx = {hour_q[7:5], hr_inc[4:0]};
      end
    end else begin
      hr_inc = bcd_inc({2'b00, hour_q[5:0]});
      if (hour_q[5:0] == 6'h23) begin
        hour_nx  = {hour_q[7:6], 6'h00};
        turnover = 1'b1;
      end else begin
        hour_nx = {hour_q[7:6], hr_inc[5:0]};
      end
    end
  end

  always_comb begin
    sec_d  = sec_q;
    min_d  = min_q;
    hour_d = hour_q;
    if (sec_wr)         sec_d = wr_data;
    else if (sec_step)  sec_d = (sec_q == 8'h59) ? 8'h00 : sec_inc;
    if (min_wr)         min_d = wr_data;
    else if (min_step)  min_d = (min_q == 8'h59) ? 8'h00 : min_inc;
    if (hour_wr)        hour_d = wr_data;
    else if (hour_step) hour_d = hour_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      sec_q  <= sec_d;
      min_q  <= min_d;
      hour_q <= hour_d;
    end
  end

  // R1
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && sec_q == 8'h59 && !sec_wr) |=> (sec_q == 8'h00));
  // R2
  hour24_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_step && hour_q == 8'h23 && !hour_wr) |=> (hour_q == 8'h00));
  // R3
  hour12_pm_am_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_step && hour_q == 8'h71 && !hour_wr) |=> (hour_q == 8'h52));
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               day_step,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] dow_q,
  output logic [FIELD_W-1:0] date_q,
  output logic [FIELD_W-1:0] month_q,
  output logic [FIELD_W-1:0] year_q
);
  logic [FIELD_W-1:0] dow_d, date_d, month_d, year_d;
  logic [FIELD_W-1:0] last_day, date_inc, mon_inc, year_inc;
  logic dow_wr, date_wr, month_wr, year_wr;
  logic mon_step, yr_step, mon_wrap, yr_wrap;

  assign dow_wr   = wr_en && (wr_addr == A_DOW);
  assign date_wr  = wr_en && (wr_addr == A_DATE);
  assign month_wr = wr_en && (wr_addr == A_MONTH);
  assign year_wr  = wr_en && (wr_addr == A_YEAR);

  assign last_day = month_last(month_q[4:0], year_q);
  assign date_inc = bcd_inc(date_q);
  assign mon_inc  = bcd_inc({3'b000, month_q[4:0]});
  assign year_inc = bcd_inc(year_q);
  assign mon_step = day_step && (date_q == last_day);
  assign mon_wrap = (month_q[4:0] == 5'h12);
  assign yr_step  = mon_step && mon_wrap;
  assign yr_wrap  = (year_q == 8'h99);

  always_comb begin
    dow_d   = dow_q;
    date_d  = date_q;
    month_d = month_q;
    year_d  = year_q;
    if (dow_wr)        dow_d = wr_data;
    else if (day_step) dow_d = (dow_q[2:0] == 3'd7) ? 8'h01 : dow_q + 8'h01;
    if (date_wr)       date_d = wr_data;
    else if (day_step) date_d = (date_q == last_day) ? 8'h01 : date_inc;
    if (month_wr)      month_d = wr_data;
    else if (mon_step) month_d = {month_q[7] ^ (yr_step && yr_wrap), 2'b00,
                                  mon_wrap ? 5'h01 : mon_inc[4:0]};
    if (year_wr)       year_d = wr_data;
    else if (yr_step)  year_d = yr_wrap ? 8'h00 : year_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q   <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      dow_q   <= dow_d;
      date_q  <= date_d;
      month_q <= month_d;
      year_q  <= year_d;
    end
  end

  // R4
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && dow_q == 8'h07 && !dow_wr) |=> (dow_q == 8'h01));
  // R5
  date31_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && date_q == 8'h31 && !date_wr) |=> (date_q == 8'h01));
  // R6
  century_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && date_q == 8'h31 && month_q[4:0] == 5'h12 && year_q == 8'h99
     && !month_wr && !year_wr) |=> (month_q[7] != $past(month_q[7])));
endmodule

// File: rtl/bcd_rtc_counter.sv
module bcd_rtc_counter
  import rtc_cal_pkg::*;
#(
  parameter int PRESC_BITS = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_32k,
  input  logic               osc_halt,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] sec_o,
  output logic [FIELD_W-1:0] min_o,
  output logic [FIELD_W-1:0] hour_o,
  output logic [FIELD_W-1:0] dow_o,
  output logic [FIELD_W-1:0] date_o,
  output logic [FIELD_W-1:0] month_o,
  output logic [FIELD_W-1:0] year_o,
  output logic               sec_tick,
  output logic               phase_1hz
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       sec_restart;
  logic       day_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n   = rst_sync_q[1];
  assign sec_restart = wr_en && (wr_addr == A_SEC);

  rtc_prescaler #(.PRESC_BITS(PRESC_BITS)) u_presc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_in  (tick_32k),
    .halt     (osc_halt),
    .restart  (sec_restart),
    .sec_tick (sec_tick),
    .phase    (phase_1hz)
  );

  rtc_time_chain u_time (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sec_step (sec_tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sec_q    (sec_o),
    .min_q    (min_o),
    .hour_q   (hour_o),
    .day_step (day_step)
  );

  rtc_date_chain u_date (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .day_step (day_step),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .dow_q    (dow_o),
    .date_q   (date_o),
    .month_q  (month_o),
    .year_q   (year_o)
  );

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (osc_halt && !wr_en) |=> ($stable(sec_o) && $stable(phase_1hz)));
  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_addr == A_MIN) |=> (min_o == $past(wr_data)));
endmodule

// File: tb/bcd_rtc_counter_test.sv
module bcd_rtc_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int PB         = 4;
  localparam int SEC_TICKS  = 1 << PB;
  localparam int NVEC       = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_32k, osc_halt, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       sec_tick, phase_1hz;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_counter #(.PRESC_BITS(PB)) uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .osc_halt(osc_halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .sec_tick(sec_tick), .phase_1hz(phase_1hz)
  );

  // {sec,min,hour,dow,date,month,year} loaded, then expected one second later
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h59_00_00_03_15_06_24, 56'h00_01_00_03_15_06_24}, // R1 minute carry
    {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_81_00}, // R2 R4 R6 century
    {56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23}, // R5 non-leap Feb
    {56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24}, // R5 leap Feb 29
    {56'h59_59_23_03_29_02_24, 56'h00_00_00_04_01_03_24}, // R5 leap Mar 1
    {56'h59_59_23_05_30_04_10, 56'h00_00_00_06_01_05_10}, // R5 30-day month
    {56'h59_59_23_01_31_81_00, 56'h00_00_00_02_01_82_00}, // R6 century kept
    {56'h59_59_51_02_10_05_20, 56'h00_00_72_02_10_05_20}, // R3 11AM->12PM
    {56'h59_59_72_02_10_05_20, 56'h00_00_61_02_10_05_20}, // R3 12PM->1PM
    {56'h59_59_71_04_10_05_20, 56'h00_00_52_05_11_05_20}, // R3 11PM->12AM
    {56'h59_59_09_04_10_05_20, 56'h00_00_10_04_10_05_20}, // R1 hour tens
    {56'h59_59_52_04_10_05_20, 56'h00_00_41_04_10_05_20}  // R3 12AM->1AM
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] fld(input logic [55:0] v, input int k);
    return v[55-8*k -: 8];
  endfunction

  task automatic get_fields(output logic [55:0] v);
    v = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [55:0] got;
    int ticks;
    bit prev;
    rst_n = 1'b0; tick_32k = 1'b1; osc_halt = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset values
    get_fields(got);
    check("R11", got[55:48], 8'h00);
    check("R11", got[47:40], 8'h00);
    check("R11", got[39:32], 8'h00);
    check("R11", got[31:24], 8'h01);
    check("R11", got[23:16], 8'h01);
    check("R11", got[15:8],  8'h01);
    check("R11", got[7:0],   8'h00);

    // vector walk
    for (int i = 0; i < NVEC; i++) begin
      logic [55:0] ld, ex;
      ld = VEC[i][111:56];
      ex = VEC[i][55:0];
      osc_halt = 1'b1;
      for (int k = 6; k >= 0; k--) wr(3'(k), fld(ld, k));
      osc_halt = 1'b0;
      repeat (SEC_TICKS) @(negedge clk);
      get_fields(got);
      for (int k = 0; k < 7; k++)
        check($sformatf("R1-vec%0d-f%0d", i, k), fld(got, k), fld(ex, k));
    end

    // R7 restart and phase
    wr(3'd1, 8'h10);
    wr(3'd0, 8'h30);
    repeat (SEC_TICKS/2 - 1) @(negedge clk);
    check("R7 phase low", {7'd0, phase_1hz}, 8'h00);
    @(negedge clk);
    check("R7 phase high", {7'd0, phase_1hz}, 8'h01);
    repeat (SEC_TICKS/2 - 1) @(negedge clk);
    check("R7 no early step", sec_o, 8'h30);
    @(negedge clk);
    check("R7 step", sec_o, 8'h31);

    // R9 strobe count over three seconds
    wr(3'd0, 8'h05);
    ticks = 0; prev = 1'b0;
    for (int c = 0; c < 3*SEC_TICKS; c++) begin
      if (sec_tick) ticks++;
      if (sec_tick && prev) ticks += 100;
      prev = sec_tick;
      @(negedge clk);
    end
    check("R9 strobe count", 8'(ticks), 8'd3);

    // R8 halt
    wr(3'd0, 8'h20);
    osc_halt = 1'b1;
    repeat (40) @(negedge clk);
    check("R8 halted sec", sec_o, 8'h20);
    check("R8 halted phase", {7'd0, phase_1hz}, 8'h00);
    osc_halt = 1'b0;
    repeat (SEC_TICKS - 1) @(negedge clk);
    check("R8 resume early", sec_o, 8'h20);
    @(negedge clk);
    check("R8 resume step", sec_o, 8'h21);

    // R10 write beats carry
    wr(3'd1, 8'h10);
    wr(3'd0, 8'h59);
    repeat (SEC_TICKS - 1) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 sec rolled", sec_o, 8'h00);
    check("R10 min written", min_o, 8'h33);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule